// File: doc/BRIEF.md
# Lockable Secure Monotonic Counter

This block keeps a count that software can only move forward. The count is split across two registers, an upper word and a lower word. A write to either register never loads the written data. It asks for one increment, and the written value is discarded. An increment happens only when a count-valid control bit is set and neither of two lock levels is engaged. The same two locks also freeze the count-valid bit, so locked software cannot enable or disable counting.

The upper count register shows a 16-bit era value in its top half. The era value comes straight from an input port, which is normally tied to fuses. When the count reaches its all-ones value, it stays there. A sticky rollover flag is set and the count-valid bit is cleared in the same cycle. A 32-bit scratch register sits behind its own pair of soft and hard locks.

Access is through a plain register bus. A write is one cycle with `bus_en` and `bus_we` both high, and it always completes, so there is no back-pressure. Reads are combinational: `bus_rdata` follows `bus_addr` in the same cycle.

Register map (word addresses):

| Addr | Name | Contents |
|------|------|----------|
| 0 | SOFT_LOCK | bit 0 counter soft lock, bit 1 scratch soft lock; read/write |
| 1 | HARD_LOCK | bit 0 counter hard lock, bit 1 scratch hard lock; write 1 to set |
| 2 | CTRL | bit 0 count-valid |
| 3 | STATUS | bit 0 rollover; write 1 to clear |
| 4 | COUNT_HI | bits 15:0 count upper part, bits 31:16 era input; write increments |
| 5 | COUNT_LO | bits 31:0 count lower part; write increments |
| 6 | SCRATCH | 32-bit general-purpose data |

Top module: `mcv_top`

## Requirements
- R1: A write to address 4 or address 5 advances the count by exactly one, whatever data is written, when count-valid is set and the counter is not locked.
- R2: The count is 48 bits wide by default. Address 5 reads count bits 31:0, and bits 15:0 of address 4 read count bits 47:32. The widths are set by the parameters `CNT_HI_W` and `CNT_LO_W`.
- R3: Bits 31:16 of address 4 always show the current value of `era_in`.
- R4: While CTRL bit 0 (count-valid) is 0, writes to addresses 4 and 5 leave the count unchanged.
- R5: When SOFT_LOCK bit 0 or HARD_LOCK bit 0 is set, increments are blocked and writes to CTRL bit 0 are ignored.
- R6: SOFT_LOCK bits can be set and cleared by writes. HARD_LOCK bits are set by writing 1 and clear only on reset.
- R7: When an increment brings the count to all ones, STATUS bit 0 is set, count-valid is cleared and the count holds. Further accepted increments do not wrap the count, and they clear count-valid again.
- R8: Writing 1 to STATUS bit 0 clears the rollover flag. Writing 0 to it has no effect.
- R9: Writes to address 6 are ignored while SOFT_LOCK bit 1 or HARD_LOCK bit 1 is set.
- R10: After reset, all stored state is zero, and addresses other than 0 to 6 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write qualifier; a write takes place when bus_en and bus_we are both high |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| era_in | input | ERA_W | Era value shown in the upper count register |

## Verification
All state in this block can be read back combinationally, so a wrong internal value shows on `bus_rdata` in the cycle after the write that caused it. A count that skipped, loaded written data or wrapped would show up at once as a mismatch against the bench's arithmetic count. A lock that failed to hold would show as a changed count, count-valid bit or scratch value on the next read. A reduced 5-bit counter is swept through every value up to its ceiling, so the rollover and hold logic is exercised in a few hundred cycles.

// File: rtl/mcv_pkg.sv
package mcv_pkg;
  // word addresses of the register map
  localparam int unsigned REG_SOFT_LOCK = 0;
  localparam int unsigned REG_HARD_LOCK = 1;
  localparam int unsigned REG_CTRL      = 2;
  localparam int unsigned REG_STATUS    = 3;
  localparam int unsigned REG_COUNT_HI  = 4;
  localparam int unsigned REG_COUNT_LO  = 5;
  localparam int unsigned REG_SCRATCH   = 6;

  // lock bit positions, shared by both lock registers
  localparam int unsigned LK_COUNT   = 0;
  localparam int unsigned LK_SCRATCH = 1;
  localparam int unsigned LK_NUM     = 2;

  // era field position in the upper count register
  localparam int unsigned ERA_LSB = 16;
endpackage

// File: rtl/mcv_lock_bank.sv
module mcv_lock_bank #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_soft,
  input  logic         wr_hard,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] soft_q,
  output logic [N-1:0] hard_q
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        soft_q[g] <= 1'b0;
      end else if (wr_soft) begin
        soft_q[g] <= wdata[g];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hard_q[g] <= 1'b0;
      end else if (wr_hard && wdata[g]) begin
        hard_q[g] <= 1'b1;
      end
    end

    // R6: a hard lock never drops while out of reset
    assert_hard_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hard_q[g] |=> hard_q[g]);
  end
endmodule

// File: rtl/mcv_counter.sv
module mcv_counter #(
  parameter int unsigned HI_W = 16,
  parameter int unsigned LO_W = 32,
  localparam int unsigned CNT_W = HI_W + LO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_req,
  input  logic             locked,
  input  logic             ctrl_wr,
  input  logic             ctrl_wdata,
  input  logic             stat_wr,
  input  logic             stat_w1c,
  output logic [CNT_W-1:0] cnt,
  output logic             valid,
  output logic             rollover
);
  logic [CNT_W-1:0] cnt_nxt;
  logic             at_max;
  logic             inc_go;

  assign cnt_nxt = cnt + 1'b1;
  assign at_max  = (cnt == '1);
  assign inc_go  = inc_req && valid && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (inc_go && !at_max) begin
      cnt <= cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
    end else if (inc_go && (at_max || cnt_nxt == '1)) begin
      valid <= 1'b0;
    end else if (ctrl_wr && !locked) begin
      valid <= ctrl_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rollover <= 1'b0;
    end else if (inc_go && (at_max || cnt_nxt == '1)) begin
      rollover <= 1'b1;
    end else if (stat_wr && stat_w1c) begin
      rollover <= 1'b0;
    end
  end

  // R1: the count never moves by anything other than zero or one
  assert_step_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1));
  // R4: without count-valid a request leaves the count alone
  assert_invalid_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_req && !valid) |=> $stable(cnt));
  // R5: a locked counter neither counts nor takes a control write
  assert_locked_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(cnt));
  assert_locked_ctrl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && locked && !inc_req) |=> $stable(valid));
  // R7: the ceiling holds and rollover rises only there
  assert_max_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    at_max |=> (cnt == '1));
  assert_roll_at_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rollover) |-> (cnt == '1));
endmodule

// File: rtl/mcv_scratch.sv
module mcv_scratch #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic         locked,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr && !locked) begin
      q <= wdata;
    end
  end

  // R9: a locked scratch register keeps its value
  assert_scratch_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(q));
endmodule

// File: rtl/mcv_top.sv
module mcv_top #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CNT_HI_W = 16,
  parameter int unsigned CNT_LO_W = 32,
  parameter int unsigned ERA_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [ERA_W-1:0]  era_in
);
  import mcv_pkg::*;

  localparam int unsigned CNT_W = CNT_HI_W + CNT_LO_W;

  logic              wr;
  logic              wr_soft, wr_hard, wr_ctrl, wr_stat, wr_hi, wr_lo, wr_scr;
  logic [LK_NUM-1:0] soft_q, hard_q;
  logic [CNT_W-1:0]  cnt;
  logic              valid, rollover;
  logic [DATA_W-1:0] scr_q;
  logic [DATA_W-1:0] rd_hi, rd_lo;

  assign wr      = bus_en && bus_we;
  assign wr_soft = wr && (bus_addr == ADDR_W'(REG_SOFT_LOCK));
  assign wr_hard = wr && (bus_addr == ADDR_W'(REG_HARD_LOCK));
  assign wr_ctrl = wr && (bus_addr == ADDR_W'(REG_CTRL));
  assign wr_stat = wr && (bus_addr == ADDR_W'(REG_STATUS));
  assign wr_hi   = wr && (bus_addr == ADDR_W'(REG_COUNT_HI));
  assign wr_lo   = wr && (bus_addr == ADDR_W'(REG_COUNT_LO));
  assign wr_scr  = wr && (bus_addr == ADDR_W'(REG_SCRATCH));

  mcv_lock_bank #(.N(LK_NUM)) u_locks (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_soft (wr_soft),
    .wr_hard (wr_hard),
    .wdata   (bus_wdata[LK_NUM-1:0]),
    .soft_q  (soft_q),
    .hard_q  (hard_q)
  );

  mcv_counter #(.HI_W(CNT_HI_W), .LO_W(CNT_LO_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc_req    (wr_hi || wr_lo),
    .locked     (soft_q[LK_COUNT] || hard_q[LK_COUNT]),
    .ctrl_wr    (wr_ctrl),
    .ctrl_wdata (bus_wdata[0]),
    .stat_wr    (wr_stat),
    .stat_w1c   (bus_wdata[0]),
    .cnt        (cnt),
    .valid      (valid),
    .rollover   (rollover)
  );

  mcv_scratch #(.W(DATA_W)) u_scratch (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (wr_scr),
    .locked (soft_q[LK_SCRATCH] || hard_q[LK_SCRATCH]),
    .wdata  (bus_wdata),
    .q      (scr_q)
  );

  always_comb begin
    rd_hi = '0;
    rd_hi[CNT_HI_W-1:0] = cnt[CNT_W-1:CNT_LO_W];
    rd_hi[ERA_LSB +: ERA_W] = era_in;
    rd_lo = '0;
    rd_lo[CNT_LO_W-1:0] = cnt[CNT_LO_W-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(REG_SOFT_LOCK): bus_rdata[LK_NUM-1:0] = soft_q;
      ADDR_W'(REG_HARD_LOCK): bus_rdata[LK_NUM-1:0] = hard_q;
      ADDR_W'(REG_CTRL):      bus_rdata[0] = valid;
      ADDR_W'(REG_STATUS):    bus_rdata[0] = rollover;
      ADDR_W'(REG_COUNT_HI):  bus_rdata = rd_hi;
      ADDR_W'(REG_COUNT_LO):  bus_rdata = rd_lo;
      ADDR_W'(REG_SCRATCH):   bus_rdata = scr_q;
      default:                bus_rdata = '0;
    endcase
  end

  // R3: era field tracks the input whenever the upper word is addressed
  assert_era_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(REG_COUNT_HI)) |-> (bus_rdata[ERA_LSB +: ERA_W] == era_in));
  // R8: a rollover clear leaves the flag low next cycle unless an increment set it
  assert_roll_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[0]) |=> !rollover);
endmodule

// File: tb/tb_mcv_top.sv
module tb_mcv_top;
  localparam int HI_W = 2;
  localparam int LO_W = 3;
  localparam int MAXV = (1 << (HI_W + LO_W)) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] era_in = 16'hA5C3;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mcv_top #(.CNT_HI_W(HI_W), .CNT_LO_W(LO_W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .era_in(era_in)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 4'(a);
    #1 d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic chk_count(input string tag, input int c);
    logic [31:0] v;
    rd(5, v); chk({tag, " lo"}, v, 32'(c & ((1 << LO_W) - 1)));
    rd(4, v); chk({tag, " hi"}, v, {era_in, 16'(c >> LO_W)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();
    // R10 and R3: reset state and unmapped reads
    for (int a = 0; a < 16; a++) begin
      rd(a, v);
      chk("R10 reset read", v, (a == 4) ? {era_in, 16'h0} : 32'h0);
    end
    // R4: no count without valid
    wr(5, 32'hFFFF_FFFF);
    chk_count("R4 invalid write", 0);
    // R1: increments ignore data
    wr(2, 1); rd(2, v); chk("R1 valid set", v, 1);
    wr(4, 0);             chk_count("R1 hi write", 1);
    wr(5, 32'hDEAD_BEEF); chk_count("R1 lo write", 2);
    // R5 soft lock, R6 soft clear
    wr(0, 1); rd(0, v); chk("R6 soft set", v, 1);
    wr(5, 7); chk_count("R5 soft blocks", 2);
    wr(2, 0); rd(2, v); chk("R5 soft guards valid", v, 1);
    wr(0, 0); rd(0, v); chk("R6 soft clear", v, 0);
    wr(4, 9); chk_count("R5 soft released", 3);
    // R5 hard lock, R6 sticky
    wr(1, 1); rd(1, v); chk("R6 hard set", v, 1);
    wr(1, 0); rd(1, v); chk("R6 hard sticky", v, 1);
    wr(4, 1); chk_count("R5 hard blocks", 3);
    wr(2, 0); rd(2, v); chk("R5 hard guards valid", v, 1);
    do_reset();
    rd(1, v); chk("R6 hard cleared by reset", v, 0);
    chk_count("R10 count after reset", 0);
    // R1 R2 R3 R7: full sweep to the ceiling
    era_in = 16'h3C5A;
    wr(2, 1);
    for (int i = 1; i <= MAXV; i++) begin
      wr((i % 2) ? 5 : 4, 32'(i) * 32'h9E37_79B9);
      chk_count("R2 sweep", i);
      rd(2, v); chk("R7 valid in sweep", v, (i == MAXV) ? 0 : 1);
      rd(3, v); chk("R7 rollover in sweep", v, (i == MAXV) ? 1 : 0);
    end
    // R7: hold at ceiling
    wr(5, 0); chk_count("R7 hold invalid", MAXV);
    wr(2, 1); wr(4, 0); chk_count("R7 hold revalid", MAXV);
    rd(2, v); chk("R7 valid cleared again", v, 0);
    // R8: write-one-to-clear
    wr(3, 0); rd(3, v); chk("R8 zero write keeps", v, 1);
    wr(3, 1); rd(3, v); chk("R8 one write clears", v, 0);
    // R9: scratch locks
    wr(6, 32'h1234_5678); rd(6, v); chk("R9 open write", v, 32'h1234_5678);
    wr(0, 2); wr(6, 0); rd(6, v); chk("R9 soft lock", v, 32'h1234_5678);
    wr(0, 0); wr(6, 32'hCAFE_F00D); rd(6, v); chk("R9 soft released", v, 32'hCAFE_F00D);
    wr(1, 2); wr(6, 1); rd(6, v); chk("R9 hard lock", v, 32'hCAFE_F00D);
    wr(1, 0); rd(1, v); chk("R6 scratch hard sticky", v, 2);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule